// File: doc/BRIEF.md
# Pin-Change Interrupt Unit with Port Snapshot

This unit watches the pins of an 8-bit general-purpose port and turns selected pin activity into a single interrupt line. For each pin, software chooses whether it takes part and how its level is judged. It can be compared against a programmed default level, or against the level the pin had on the previous clock edge. The raw pin level is used, before any input inversion the surrounding port may apply.

The first qualifying event after an idle period copies the whole port into a snapshot register. Per-pin flags then collect every pin that raises a condition until the host clears the interrupt. The host clears it by reading either the snapshot register or the port register, which the surrounding register file reports on two one-cycle read strobes. The interrupt pin can be driven push-pull with either active level, or as an open-drain output that only pulls low.

Top module: `ioc_unit`

## Requirements
- R1: After reset, flags and snapshot are 0 and the interrupt is inactive. The previous-level reference is loaded from the pins on the first clock edge after reset, so no event is raised by pins that are steady at any level.
- R2: A pin raises a condition only when its enable bit is 1 and its direction bit is 1 (input). Changes on output pins or disabled pins leave flags at 0 and the interrupt inactive.
- R3: With its mode bit 0, an enabled input pin whose level differs from its level at the previous clock edge sets its flag bit, which is visible after that edge.
- R4: With its mode bit 1, an enabled input pin whose level differs from its default bit sets its flag bit.
- R5: The snapshot register takes the full pin vector on the edge where a condition occurs while no flag is set, and it holds while any flag stays set and no clearing read occurs.
- R6: Flag bits accumulate: a pin whose condition occurs after the snapshot was taken sets its own flag, and the snapshot is not updated.
- R7: A one-cycle read strobe for the snapshot or for the port clears all flags on that edge. If a condition occurs on the same edge, flags become exactly the pins with a condition on that edge, and the snapshot is retaken.
- R8: In default-compare mode a persisting mismatch sets the flag again on the edge of the clearing read, with a fresh snapshot. Once the pin matches its default, the next clearing read leaves flags at 0.
- R9: The interrupt is active when any flag is set. With the open-drain bit at 1, the drive enable equals active and the level is 0. With the open-drain bit at 0, the drive enable is 1 and the level is active when the polarity bit is 1, and inverted active when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Raw pin levels |
| dirMask | input | 8 | Direction per pin, 1 = input |
| enMask | input | 8 | Interrupt enable per pin |
| defVal | input | 8 | Default level per pin for default-compare mode |
| cmpMode | input | 8 | Per pin: 1 = compare with default, 0 = compare with previous level |
| openDrain | input | 1 | 1 = interrupt pin open-drain |
| activeHigh | input | 1 | Push-pull polarity, 1 = active-high |
| rdCapture | input | 1 | One-cycle strobe: snapshot register read |
| rdPort | input | 1 | One-cycle strobe: port register read |
| flags | output | 8 | Per-pin interrupt flags |
| captured | output | 8 | Port snapshot taken at the first event |
| irqLevel | output | 1 | Interrupt pin level |
| irqDriveEn | output | 1 | Interrupt pin drive enable |

## Verification
The clearing read and a fresh pin event can land on the same clock edge. The bench forces this in two ways. It pulses the snapshot read in the same cycle as a previous-level toggle on a different pin. It also reads while a default-compare mismatch persists. In both cases the outcome must be flags holding only the new pins and a snapshot equal to the pins on that edge. A behavioural model updated on every edge checks all four outputs each cycle, and directed checks pin down the expected constants.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  typedef struct packed {
    logic primed;
    logic clearAll;
    logic takeCap;
  } iocStrobe_t;
endpackage

// File: rtl/ioc_ctrl.sv
module ioc_ctrl
  import ioc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdCapture,
  input  logic       rdPort,
  input  logic       anyCond,
  input  logic       irqActive,
  input  logic       openDrain,
  input  logic       activeHigh,
  output iocStrobe_t strobe,
  output logic       irqLevel,
  output logic       irqDriveEn
);
  logic primedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  always_comb begin
    strobe.primed   = primedQ;
    strobe.clearAll = rdCapture | rdPort;
    strobe.takeCap  = anyCond & (strobe.clearAll | ~irqActive);
  end

  always_comb begin
    if (openDrain) begin
      irqDriveEn = irqActive;
      irqLevel   = 1'b0;
    end else begin
      irqDriveEn = 1'b1;
      irqLevel   = activeHigh ? irqActive : ~irqActive;
    end
  end

  // R9: open-drain never drives high
  a_r9_open_drain_low: assert property (@(posedge clk) disable iff (!rstN)
    openDrain |-> (irqLevel == 1'b0));
  // R5: no new snapshot while pending without a read
  a_r5_no_recapture: assert property (@(posedge clk) disable iff (!rstN)
    (irqActive && !rdCapture && !rdPort) |-> !strobe.takeCap);
endmodule

// File: rtl/ioc_datapath.sv
module ioc_datapath
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  input  logic [W-1:0] dirMask,
  input  logic [W-1:0] enMask,
  input  logic [W-1:0] defVal,
  input  logic [W-1:0] cmpMode,
  input  iocStrobe_t   strobe,
  output logic [W-1:0] flags,
  output logic [W-1:0] captured,
  output logic         anyCond,
  output logic         irqActive
);
  logic [W-1:0] refQ;
  logic [W-1:0] cond;
  logic [W-1:0] flagQ;
  logic [W-1:0] capQ;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      cond[i] = strobe.primed & enMask[i] & dirMask[i] &
                (cmpMode[i] ? (pinIn[i] ^ defVal[i]) : (pinIn[i] ^ refQ[i]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refQ[i]  <= 1'b0;
        flagQ[i] <= 1'b0;
      end else begin
        refQ[i]  <= pinIn[i];
        flagQ[i] <= (strobe.clearAll ? 1'b0 : flagQ[i]) | cond[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capQ <= '0;
    else if (strobe.takeCap) capQ <= pinIn;
  end

  assign anyCond   = |cond;
  assign irqActive = |flagQ;
  assign flags     = flagQ;
  assign captured  = capQ;

  // R1: nothing flags on the priming edge
  a_r1_quiet_priming: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.primed |=> (flagQ == '0));
  // R2: newly set flags come only from enabled input pins
  a_r2_masked_pins: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & ~$past(flagQ)) & ~$past(enMask & dirMask)) == '0);
  // R5: snapshot holds while pending and not read
  a_r5_capture_holds: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ != '0 && !strobe.clearAll) |=> $stable(capQ));
  // R7: clearing read with no event empties flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearAll && !anyCond) |=> (flagQ == '0));
endmodule

// File: rtl/ioc_unit.sv
module ioc_unit
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  input  logic [W-1:0] dirMask,
  input  logic [W-1:0] enMask,
  input  logic [W-1:0] defVal,
  input  logic [W-1:0] cmpMode,
  input  logic         openDrain,
  input  logic         activeHigh,
  input  logic         rdCapture,
  input  logic         rdPort,
  output logic [W-1:0] flags,
  output logic [W-1:0] captured,
  output logic         irqLevel,
  output logic         irqDriveEn
);
  iocStrobe_t strobe;
  logic       anyCond;
  logic       irqActive;

  ioc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdCapture  (rdCapture),
    .rdPort     (rdPort),
    .anyCond    (anyCond),
    .irqActive  (irqActive),
    .openDrain  (openDrain),
    .activeHigh (activeHigh),
    .strobe     (strobe),
    .irqLevel   (irqLevel),
    .irqDriveEn (irqDriveEn)
  );

  ioc_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .dirMask   (dirMask),
    .enMask    (enMask),
    .defVal    (defVal),
    .cmpMode   (cmpMode),
    .strobe    (strobe),
    .flags     (flags),
    .captured  (captured),
    .anyCond   (anyCond),
    .irqActive (irqActive)
  );
endmodule

// File: tb/ioc_unit_test.sv
`timescale 1ns/1ps
module ioc_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = 8'h5A, dirMask = 8'hFF, enMask = 8'hFF;
  logic [7:0] defVal = 8'h00, cmpMode = 8'h00;
  logic       openDrain = 1'b0, activeHigh = 1'b1;
  logic       rdCapture = 1'b0, rdPort = 1'b0;
  logic [7:0] flags, captured;
  logic       irqLevel, irqDriveEn;

  int    nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit    finished = 0;

  always #2.5 clk = ~clk;

  ioc_unit uut (.*);

  // behavioural reference model
  logic [7:0] mFlags, mCap, mPrev;
  bit         mPrimed;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlags = 0; mCap = 0; mPrev = 0; mPrimed = 0;
    end else begin
      logic [7:0] hit;
      bit         wasIdle;
      hit = 0;
      for (int i = 0; i < 8; i++) begin
        bit ref_bit;
        ref_bit = cmpMode[i] ? defVal[i] : mPrev[i];
        if (mPrimed && enMask[i] && dirMask[i] && pinIn[i] != ref_bit) hit[i] = 1;
      end
      wasIdle = (mFlags == 0);
      if (rdCapture || rdPort) mFlags = 0;
      if (hit != 0 && (wasIdle || rdCapture || rdPort)) mCap = pinIn;
      mFlags = mFlags | hit;
      mPrev = pinIn;
      mPrimed = 1;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit act, expLvl, expEn;
      act    = (mFlags != 0);
      expEn  = openDrain ? act : 1'b1;
      expLvl = openDrain ? 1'b0 : (activeHigh ? act : !act);
      chk(curReq, "model flags", flags, mFlags);
      chk(curReq, "model capture", captured, mCap);
      chk(curReq, "model level", {7'd0, irqLevel}, {7'd0, expLvl});
      chk(curReq, "model drive", {7'd0, irqDriveEn}, {7'd0, expEn});
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    // R1: steady non-zero pins produce nothing after reset
    step(3);
    chk("R1", "flags", flags, 8'h00);
    chk("R1", "capture", captured, 8'h00);
    chk("R1", "level", {7'd0, irqLevel}, 8'h00);
    chk("R1", "drive", {7'd0, irqDriveEn}, 8'h01);

    curReq = "R3"; pinIn = 8'h5B; step(1);
    chk("R3", "flags", flags, 8'h01);
    chk("R5", "capture", captured, 8'h5B);
    chk("R9", "level", {7'd0, irqLevel}, 8'h01);

    curReq = "R6"; pinIn = 8'h53; step(1);
    chk("R6", "flags", flags, 8'h09);
    chk("R6", "capture", captured, 8'h5B);

    curReq = "R7"; rdPort = 1; step(1); rdPort = 0;
    chk("R7", "flags", flags, 8'h00);
    chk("R7", "capture", captured, 8'h5B);

    curReq = "R2"; dirMask = 8'hEF; enMask = 8'hBF; pinIn = 8'h03; step(2);
    chk("R2", "flags", flags, 8'h00);
    chk("R2", "level", {7'd0, irqLevel}, 8'h00);
    dirMask = 8'hFF; enMask = 8'hFF; step(1);
    chk("R2", "flags after unmask", flags, 8'h00);

    curReq = "R4"; defVal = 8'h03; cmpMode = 8'h02; step(1);
    chk("R4", "flags match", flags, 8'h00);
    pinIn = 8'h01; step(1);
    chk("R4", "flags", flags, 8'h02);
    chk("R4", "capture", captured, 8'h01);

    curReq = "R8"; dirMask = 8'hFE; pinIn = 8'h00; step(1);
    chk("R8", "output pin ignored", flags, 8'h02);
    rdCapture = 1; step(1); rdCapture = 0;
    chk("R8", "flags re-set", flags, 8'h02);
    chk("R8", "capture retaken", captured, 8'h00);
    pinIn = 8'h02; step(1);
    chk("R8", "flags sticky", flags, 8'h02);
    rdPort = 1; step(1); rdPort = 0;
    chk("R8", "flags cleared", flags, 8'h00);
    dirMask = 8'hFF; cmpMode = 8'h00; step(1);
    chk("R8", "quiet", flags, 8'h00);

    curReq = "R7"; pinIn = 8'h0A; step(1);
    chk("R7", "flags pre", flags, 8'h08);
    chk("R7", "capture pre", captured, 8'h0A);
    rdCapture = 1; pinIn = 8'h0B; step(1); rdCapture = 0;
    chk("R7", "collision flags", flags, 8'h01);
    chk("R7", "collision capture", captured, 8'h0B);

    curReq = "R9"; openDrain = 1; step(1);
    chk("R9", "od active drive", {7'd0, irqDriveEn}, 8'h01);
    chk("R9", "od active level", {7'd0, irqLevel}, 8'h00);
    rdPort = 1; step(1); rdPort = 0;
    chk("R9", "od idle drive", {7'd0, irqDriveEn}, 8'h00);
    openDrain = 0; activeHigh = 0; step(1);
    chk("R9", "pp low idle level", {7'd0, irqLevel}, 8'h01);
    chk("R9", "pp drive", {7'd0, irqDriveEn}, 8'h01);
    pinIn = 8'h0F; step(1);
    chk("R9", "flags", flags, 8'h04);
    chk("R9", "pp low active level", {7'd0, irqLevel}, 8'h00);

    step(2);
    summary();
  end
endmodule